// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block holds processor stores between a write-through cache and a slow main memory. Every store that the cache takes is also pushed into a small circular queue. A drain engine sends the queued stores to memory one at a time, oldest first, over a single request/acknowledge memory port. Because of the queue, the processor does not wait for the memory write cycle.

When the cache misses on a read, it hands the miss address to the block. In the cycle the miss arrives, the address is compared at word granularity against every store still pending, and the result is frozen into a drain count. If no pending store touches that word, the read takes the memory port at the next idle point, ahead of every queued store that has not yet started. If a store does match, the read waits until the youngest matching store and every store older than it have retired. It then issues ahead of any younger stores. The memory data comes back on a one-cycle response strobe.

When stores arrive faster than memory can absorb them, the queue fills. The store port then lowers its ready signal, so a store is held back and never lost. Only one read miss may be outstanding at a time. A new miss may be presented once the previous response has been seen.

Top module: `wr_queue_bypass`

## Requirements
- R1: Accepted stores reach memory as write operations in acceptance order, each exactly once, with address and data unchanged.
- R2: The queue holds DEPTH stores (4 by default). `buf_full` is high exactly when DEPTH stores are pending and `buf_empty` exactly when none are. `st_ready` is low exactly while full. A store held back by low ready is accepted later, not dropped.
- R3: A read miss that matches no pending store goes to memory before every queued store that has not started. At most the one write already in progress when the miss arrives completes first.
- R4: Address matching ignores the low log2(WORD_BYTES) bits (bits 1:0 by default). Two addresses with equal upper bits name the same word.
- R5: A read miss matching one or more pending stores issues only after the youngest matching store and all older stores have retired. It issues before any store younger than that one.
- R6: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack` is sampled high. An operation is never withdrawn.
- R7: `rd_rsp_valid` pulses for one cycle, in the cycle after the read's `mem_ack`, carrying `mem_rdata`. The data reflects every store accepted before the read request.
- R8: Stores accepted in the same cycle as a read request, or later, do not delay that read and are not visible in its data.
- R9: A matching store that retires in the same cycle as the read request arrives counts as already drained.
- R10: After reset, `buf_empty`=1, `buf_full`=0, `st_ready`=1, `mem_req`=0 and `rd_rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| buf_full | output | 1 | DEPTH stores pending |
| buf_empty | output | 1 | No store pending |
| rd_req | input | 1 | One-cycle read-miss request |
| rd_addr | input | ADDR_W | Read-miss byte address, valid with rd_req |
| rd_rsp_valid | output | 1 | Read data strobe |
| rd_rsp_data | output | DATA_W | Read data |
| mem_req | output | 1 | Memory operation requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the operation (one cycle) |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The critical overlap is a read miss arriving in the same cycle that the drain engine retires a store to the same word. The conflict check must then count that store as already gone, not wait for it a second time. The bench provokes this directly: it watches the memory model's acknowledge and presents the miss on that exact edge. It then judges the number of retired stores at the moment the read issues, along with the returned data. A second overlap, a store pushed to the missed word while the read is waiting, is judged the same way. Random traffic with varying memory latency adds many more coincidences of retirement, push and request.

// File: rtl/wqb_pkg.sv
package wqb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_WRITE = 2'd1,
      ARB_READ  = 2'd2
   } arb_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wqb_store_fifo.sv
module wqb_store_fifo #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [ADDR_W-1:0]       push_addr,
   input  logic [DATA_W-1:0]       push_data,
   input  logic                    pop,
   output logic [ADDR_W-1:0]       head_addr,
   output logic [DATA_W-1:0]       head_data,
   output logic                    full,
   output logic                    empty,
   output logic [DEPTH*ADDR_W-1:0] age_addr,
   output logic [DEPTH-1:0]        age_valid
);

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     count;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   // Age-ordered view: position 0 is the oldest pending store.
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [PW-1:0] slot;
      assign slot                        = rd_ptr + PW'(k);
      assign age_addr[k*ADDR_W +: ADDR_W] = addr_q[slot];
      assign age_valid[k]                = (CW'(k) < count);
   end

endmodule

// File: rtl/wqb_conflict.sv
module wqb_conflict #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 4,
   parameter int LSB    = 2,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int TW    = ADDR_W - LSB
) (
   input  logic [ADDR_W-1:0]       probe_addr,
   input  logic [DEPTH*ADDR_W-1:0] age_addr,
   input  logic [DEPTH-1:0]        age_valid,
   output logic [CW-1:0]           drain_need
);

   logic [DEPTH-1:0] hit;

   for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
      assign hit[k] = age_valid[k] &&
                      (age_addr[k*ADDR_W + LSB +: TW] == probe_addr[ADDR_W-1:LSB]);
   end

   // Youngest hit wins: number of stores that must retire first.
   always_comb begin
      drain_need = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (hit[k]) begin
            drain_need = CW'(k + 1);
         end
      end
   end

endmodule

// File: rtl/wqb_arbiter.sv
module wqb_arbiter
   import wqb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_avail,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CW-1:0]     rd_need,
   output logic              pop,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rd_rsp_valid,
   output logic [DATA_W-1:0] rd_rsp_data
);

   arb_state_e        state_q, state_d;
   logic              rd_pend_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [CW-1:0]     wait_q;
   logic              rd_go;

   assign pop   = (state_q == ARB_WRITE) && mem_ack;
   assign rd_go = rd_pend_q && (wait_q == '0);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ARB_IDLE: begin
            if (rd_go) begin
               state_d = ARB_READ;
            end else if (wr_avail) begin
               state_d = ARB_WRITE;
            end
         end
         ARB_WRITE: if (mem_ack) state_d = ARB_IDLE;
         ARB_READ:  if (mem_ack) state_d = ARB_IDLE;
         default:   state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ARB_IDLE;
         rd_pend_q    <= 1'b0;
         rd_addr_q    <= '0;
         wait_q       <= '0;
         rd_rsp_valid <= 1'b0;
         rd_rsp_data  <= '0;
      end else begin
         state_q      <= state_d;
         rd_rsp_valid <= 1'b0;
         if (rd_start) begin
            rd_pend_q <= 1'b1;
            rd_addr_q <= rd_addr;
            // A store retiring this very cycle is already counted in rd_need.
            if (pop && (rd_need != '0)) begin
               wait_q <= rd_need - 1'b1;
            end else begin
               wait_q <= rd_need;
            end
         end else if (rd_pend_q && pop && (wait_q != '0)) begin
            wait_q <= wait_q - 1'b1;
         end
         if ((state_q == ARB_READ) && mem_ack) begin
            rd_pend_q    <= 1'b0;
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= mem_rdata;
         end
      end
   end

   assign mem_req   = (state_q != ARB_IDLE);
   assign mem_we    = (state_q == ARB_WRITE);
   assign mem_addr  = (state_q == ARB_READ) ? rd_addr_q : head_addr;
   assign mem_wdata = head_data;

endmodule

// File: rtl/wr_queue_bypass.sv
module wr_queue_bypass
   import wqb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 4,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              buf_full,
   output logic              buf_empty,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_rsp_valid,
   output logic [DATA_W-1:0] rd_rsp_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int LSB = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
   localparam int CW  = $clog2(DEPTH + 1);

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (!is_pow2(WORD_BYTES)) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end
   if (LSB >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for WORD_BYTES");
   end

   logic                    push, pop;
   logic                    full, empty;
   logic [ADDR_W-1:0]       head_addr;
   logic [DATA_W-1:0]       head_data;
   logic [DEPTH*ADDR_W-1:0] age_addr;
   logic [DEPTH-1:0]        age_valid;
   logic [CW-1:0]           drain_need;

   assign push      = st_valid && !full;
   assign st_ready  = !full;
   assign buf_full  = full;
   assign buf_empty = empty;

   wqb_store_fifo #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .head_addr (head_addr),
      .head_data (head_data),
      .full      (full),
      .empty     (empty),
      .age_addr  (age_addr),
      .age_valid (age_valid)
   );

   wqb_conflict #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH),
      .LSB    (LSB)
   ) u_cmp (
      .probe_addr (rd_addr),
      .age_addr   (age_addr),
      .age_valid  (age_valid),
      .drain_need (drain_need)
   );

   wqb_arbiter #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_avail     (!empty),
      .head_addr    (head_addr),
      .head_data    (head_data),
      .rd_start     (rd_req),
      .rd_addr      (rd_addr),
      .rd_need      (drain_need),
      .pop          (pop),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data)
   );

endmodule

// File: rtl/wqb_checker.sv
module wqb_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic              st_ready,
   input logic              buf_full,
   input logic              buf_empty,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              rd_rsp_valid
);

   logic wr_done;
   assign wr_done = mem_req && mem_we && mem_ack;

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && (!mem_we || $stable(mem_wdata))));

   p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_full && buf_empty));

   p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && !wr_done) |=> !buf_empty);

   p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !wr_done) |=> buf_full);

   p_write_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !buf_empty);

   p_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rsp_valid |-> $past(mem_req && !mem_we && mem_ack));

endmodule

bind wr_queue_bypass wqb_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_ready     (st_ready),
   .buf_full     (buf_full),
   .buf_empty    (buf_empty),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_ack      (mem_ack),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .rd_rsp_valid (rd_rsp_valid)
);

// File: tb/sim_wr_queue_bypass.sv
module sim_wr_queue_bypass;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic          st_ready;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          buf_full, buf_empty;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_rsp_valid;
   logic [DW-1:0] rd_rsp_data;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack;
   logic [DW-1:0] mem_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   wr_queue_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .WORD_BYTES(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .buf_full(buf_full), .buf_empty(buf_empty),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] memarr [16];
   int mcnt;
   int lat_cfg = 1;
   bit lat_rand = 1'b0;
   int rnd_lat = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         mcnt      <= 0;
         for (int i = 0; i < 16; i++) memarr[i] <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (mcnt + 1 >= (lat_rand ? rnd_lat : lat_cfg)) begin
            mem_ack <= 1'b1;
            mcnt    <= 0;
            rnd_lat <= 1 + int'($urandom % 5);
            if (mem_we) memarr[mem_addr[5:2]] <= mem_wdata;
            else        mem_rdata <= memarr[mem_addr[5:2]];
         end else begin
            mcnt <= mcnt + 1;
         end
      end
   end

   // ---------------- reference model / monitor ----------------
   logic [AW-1:0] exp_addr [4096];
   logic [DW-1:0] exp_data [4096];
   logic [DW-1:0] shadow [16];
   int push_cnt = 0;
   int pop_cnt = 0;
   int rq_pop, rq_need;
   logic [DW-1:0] rq_data;
   bit rd_busy = 1'b0;
   bit rd_issued = 1'b0;
   bit st_acc = 1'b0;
   bit prev_pend = 1'b0;
   logic [AW-1:0] prev_addr;
   string cur_tag = "R7";

   initial for (int i = 0; i < 16; i++) shadow[i] = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (prev_pend) chk(mem_req && mem_addr == prev_addr, "R6", {31'd0, mem_req, mem_addr}, {32'd1, prev_addr});
         prev_pend = mem_req && !mem_ack;
         prev_addr = mem_addr;
         if (rd_req) begin
            rq_need = 0;
            for (int k = pop_cnt; k < push_cnt; k++)
               if (exp_addr[k][AW-1:2] == rd_addr[AW-1:2]) rq_need = k - pop_cnt + 1;
            rq_pop    = pop_cnt;
            rq_data   = shadow[rd_addr[5:2]];
            rd_issued = 1'b0;
         end
         if (mem_req && !mem_we && rd_busy && !rd_issued) begin
            rd_issued = 1'b1;
            if (rq_need > 0)
               chk(pop_cnt == rq_pop + rq_need, "R5 retired-before-read", pop_cnt, rq_pop + rq_need);
            else
               chk(pop_cnt <= rq_pop + 1, "R3 bypass", pop_cnt, rq_pop + 1);
         end
         if (rd_rsp_valid) begin
            chk(rd_rsp_data == rq_data, cur_tag, rd_rsp_data, rq_data);
            rd_busy = 1'b0;
         end
         if (mem_req && mem_we && mem_ack) begin
            chk(mem_addr == exp_addr[pop_cnt] && mem_wdata == exp_data[pop_cnt], "R1 order",
                {mem_addr, mem_wdata}, {exp_addr[pop_cnt], exp_data[pop_cnt]});
            pop_cnt++;
         end
         if (st_valid && st_ready) begin
            exp_addr[push_cnt] = st_addr;
            exp_data[push_cnt] = st_data;
            shadow[st_addr[5:2]] = st_data;
            push_cnt++;
            st_acc = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(buf_full == (push_cnt - pop_cnt == DEPTH), "R2 full", buf_full, push_cnt - pop_cnt);
         chk(buf_empty == (push_cnt == pop_cnt), "R2 empty", buf_empty, push_cnt - pop_cnt);
         chk(st_ready == (push_cnt - pop_cnt < DEPTH), "R2 ready", st_ready, push_cnt - pop_cnt);
      end
   end

   // ---------------- drivers ----------------
   task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      st_acc   = 1'b0;
      do @(negedge clk); while (!st_acc);
      st_valid = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string tag);
      while (rd_busy) @(negedge clk);
      @(negedge clk);
      cur_tag = tag;
      rd_req  = 1'b1;
      rd_addr = a;
      rd_busy = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic wait_quiet();
      do @(negedge clk); while (rd_busy || mem_req || !buf_empty);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(buf_empty && !buf_full && st_ready && !mem_req && !rd_rsp_valid, "R10 reset",
          {buf_empty, buf_full, st_ready, mem_req, rd_rsp_valid}, 5'b10100);

      // D1: fill, stall, bypass with no conflict
      lat_cfg = 8;
      for (int i = 0; i < DEPTH; i++) push_store(AW'(i * 4), DW'(32'hA000 + i));
      chk(buf_full && !st_ready, "R2 full after fill", {buf_full, st_ready}, 2'b10);
      fork
         push_store(AW'(4 * 4), 32'hA004);
         do_read(AW'(10 * 4), "R3");
      join
      wait_quiet();

      // D2: conflict with repeated word, read address with different low bits
      lat_cfg = 3;
      push_store(AW'(5 * 4), 32'hB001);
      push_store(AW'(6 * 4), 32'hB002);
      push_store(AW'(5 * 4 + 1), 32'hB003);
      push_store(AW'(7 * 4), 32'hB004);
      do_read(AW'(5 * 4 + 2), "R4");
      wait_quiet();

      // D3: read arrives in the cycle its matching store retires
      lat_cfg = 4;
      push_store(AW'(9 * 4), 32'hC009);
      while (!(mem_ack && mem_we)) @(negedge clk);
      cur_tag = "R9";
      rd_req  = 1'b1;
      rd_addr = AW'(9 * 4);
      rd_busy = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      wait_quiet();

      // D4: store to the same word pushed while the read waits
      lat_cfg = 6;
      push_store(AW'(11 * 4), 32'hD001);
      do_read(AW'(11 * 4 + 3), "R8");
      push_store(AW'(11 * 4), 32'hD002);
      wait_quiet();
      do_read(AW'(11 * 4), "R7 after drain");
      wait_quiet();

      // Random phase
      lat_rand = 1'b1;
      for (int n = 0; n < 1500; n++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 2 && !rd_busy)
            do_read({26'd0, 4'($urandom), 2'($urandom)}, "R7");
         else if (r < 8)
            push_store({26'd0, 4'($urandom), 2'($urandom)}, $urandom);
         else
            @(negedge clk);
      end
      wait_quiet();
      chk(push_cnt == pop_cnt && buf_empty, "R1 all retired", pop_cnt, push_cnt);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule